// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block collects up to eight interrupt request lines and presents one interrupt signal to a processor. The processor programs it over a byte-wide register port that has one address bit, a chip select and separate read and write strobes. A short start-up sequence sets the trigger style, the vector base, single or cascade wiring and an optional mode word. After that, command writes at the low address select which register a low-address read returns, arm a poll, switch special masking on or off, and retire in-service levels. Writes at the high address load the mask.

A one-cycle acknowledge pulse takes the best pending level: it moves that level from the request register into the in-service register and places the vector byte on the data output. A poll read does the same work as an acknowledge, but instead of a vector it returns a flag and the level number, so a processor with interrupts disabled can service the lines by polling. Line 0 has the highest priority. A level that is in service holds back itself and every lower level until it is retired. Automatic retirement at acknowledge time removes that hold, and special masking lets a masked in-service level stop blocking.

All read data is registered: `dout` updates on the clock edge where the read or acknowledge strobe is sampled and keeps its value afterwards.

Top module: `pic8_ctrl`

## Requirements
- R1: A low-address write with bit 4 = 1 starts set-up. It clears the mask, the request and in-service registers, automatic retirement, special masking and any armed poll, and it selects the request register for low-address reads. Bit 3 picks level (1) or edge (0) triggering, bit 1 picks single (1) or cascade (0) wiring, and bit 0 asks for a mode word. The next high-address write gives the vector base in bits 7..3. A cascade word follows only when bit 1 was 0, and it is swallowed without touching the mask. The mode word follows only when bit 0 was 1. `intr` stays low from reset, and from the start of set-up, until the sequence completes.
- R2: Outside set-up, a high-address write loads the mask, and a high-address read returns it. A mask bit of 1 stops the line with the same number from raising `intr`, from being polled and from being acknowledged.
- R3: In edge mode a request is latched only when its line goes from 0 to 1. A line that stays high after it is serviced raises no new request.
- R4: In level mode the request register follows the lines. If the line has dropped by the time of an acknowledge, the controller returns base | 7 and sets no in-service bit.
- R5: Line 0 has the highest priority and line 7 the lowest. `intr` is high exactly when some unmasked request ranks strictly above every in-service level.
- R6: An acknowledge pulse moves the winning level from the request register to the in-service register. The `dout` that follows is base | level.
- R7: A low-address write of 0x20 clears the highest-priority in-service bit. A write of 0x60 + n clears in-service bit n only.
- R8: Low-address writes of 0x0A and 0x0B make later low-address reads return the request register and the in-service register respectively.
- R9: After a low-address write with bit 3 = 1 and bit 2 = 1 (for example 0x0C), the next low-address read acts as an acknowledge. It returns 0x80 | level when an unmasked request can win, or 0x00 when none can. Reads after it return the selected register again.
- R10: When bit 1 of the mode word is 1, an acknowledge sets no in-service bit, so it leaves nothing that blocks later requests.
- R11: A low-address write 0x68 turns special masking on and 0x48 turns it off. While it is on, an in-service level whose mask bit is 1 stops blocking lower-priority levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| a0 | input | 1 | Register address bit |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read, poll or vector data |
| irq_in | input | 8 | Interrupt request lines, bit 0 highest priority |
| inta | input | 1 | Acknowledge pulse from the processor |
| intr | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a masked in-service level that stops blocking under special masking. The stimulus first acknowledges line 0, then raises line 6 and shows that it stays blocked while only the mask is set. It then turns special masking on and acknowledges line 6, so both levels are in service at once, and retires them one by one with non-specific commands. The spurious vector needs a level-mode request that is latched and then removed before the acknowledge. The stimulus raises line 5, confirms `intr`, drops the line and only then pulses the acknowledge.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NLINE = 8;
    localparam int DW    = 8;
    localparam int LVLW  = $clog2(NLINE);
    localparam int VBW   = DW - LVLW;
    localparam int PADW  = DW - 1 - LVLW;

    typedef enum logic [1:0] {
        ST_RDY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_t;

    typedef struct packed {
        logic           lvl_trig;
        logic           single;
        logic           need_mode;
        logic           auto_eoi;
        logic           spec_mask;
        logic           show_isr;
        logic           poll_arm;
        logic [VBW-1:0] vbase;
    } cfg_t;

    typedef struct packed {
        logic            hit;
        logic [LVLW-1:0] idx;
    } pick_t;

    // lowest-numbered set bit wins (line 0 is top priority)
    function automatic pick_t pick_first(input logic [NLINE-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NLINE - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = LVLW'(i);
            end
        end
        return p;
    endfunction

    // levels that rank strictly above the picked one, all levels if none
    function automatic logic [NLINE-1:0] above(input pick_t p);
        logic [NLINE-1:0] m;
        m = '1;
        if (p.hit) begin
            for (int i = 0; i < NLINE; i++) begin
                m[i] = (i < int'(p.idx));
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/pic8_reqreg.sv
module pic8_reqreg
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_trig,
    input  logic             flush,
    input  logic [NLINE-1:0] line_in,
    input  logic [NLINE-1:0] take_vec,
    output logic [NLINE-1:0] req
);
    generate
        for (genvar g = 0; g < NLINE; g++) begin : g_line
            logic prev_q;
            logic req_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    req_q  <= 1'b0;
                end else begin
                    prev_q <= line_in[g];
                    if (flush) begin
                        req_q <= 1'b0;
                    end else if (lvl_trig) begin
                        req_q <= line_in[g] & ~take_vec[g];
                    end else begin
                        req_q <= (req_q | (line_in[g] & ~prev_q)) & ~take_vec[g];
                    end
                end
            end
            assign req[g] = req_q;
        end
    endgenerate
endmodule

// File: rtl/pic8_resolve.sv
module pic8_resolve
    import pic8_pkg::*;
(
    input  logic [NLINE-1:0] irr,
    input  logic [NLINE-1:0] imr,
    input  logic [NLINE-1:0] isr,
    input  logic             spec_mask,
    output pick_t            win
);
    logic [NLINE-1:0] blk;
    logic [NLINE-1:0] cand;
    pick_t            top_srv;

    always_comb begin
        blk     = spec_mask ? (isr & ~imr) : isr;
        top_srv = pick_first(blk);
        cand    = irr & ~imr & above(top_srv);
        win     = pick_first(cand);
    end
endmodule

// File: rtl/pic8_bus.sv
module pic8_bus
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rd_lo,
    input  logic [DW-1:0]    din,
    output cfg_t             cfg,
    output logic [NLINE-1:0] imr,
    output logic             busy,
    output logic             armed,
    output logic             flush,
    output logic             eoi_any,
    output logic             eoi_spec,
    output logic [LVLW-1:0]  eoi_lvl,
    output logic             poll_take
);
    init_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_RDY;
            cfg   <= '0;
            imr   <= '0;
            armed <= 1'b0;
        end else begin
            if (rd_lo && cfg.poll_arm) begin
                cfg.poll_arm <= 1'b0;
            end
            if (wr_lo && din[4]) begin
                st            <= ST_BASE;
                armed         <= 1'b0;
                cfg.lvl_trig  <= din[3];
                cfg.single    <= din[1];
                cfg.need_mode <= din[0];
                cfg.auto_eoi  <= 1'b0;
                cfg.spec_mask <= 1'b0;
                cfg.show_isr  <= 1'b0;
                cfg.poll_arm  <= 1'b0;
                imr           <= '0;
            end else if (wr_lo && st == ST_RDY && din[3]) begin
                if (din[1]) cfg.show_isr <= din[0];
                if (din[2]) cfg.poll_arm <= 1'b1;
                if (din[6]) cfg.spec_mask <= din[5];
            end else if (wr_hi) begin
                case (st)
                    ST_BASE: begin
                        cfg.vbase <= din[DW-1:LVLW];
                        if (!cfg.single) begin
                            st <= ST_CASC;
                        end else if (cfg.need_mode) begin
                            st <= ST_MODE;
                        end else begin
                            st    <= ST_RDY;
                            armed <= 1'b1;
                        end
                    end
                    ST_CASC: begin
                        if (cfg.need_mode) begin
                            st <= ST_MODE;
                        end else begin
                            st    <= ST_RDY;
                            armed <= 1'b1;
                        end
                    end
                    ST_MODE: begin
                        cfg.auto_eoi <= din[1];
                        st           <= ST_RDY;
                        armed        <= 1'b1;
                    end
                    default: imr <= din;
                endcase
            end
        end
    end

    assign busy      = (st != ST_RDY);
    assign flush     = wr_lo & din[4];
    assign eoi_any   = wr_lo & ~din[4] & ~din[3] & din[5] & ~busy;
    assign eoi_spec  = eoi_any & din[6];
    assign eoi_lvl   = din[LVLW-1:0];
    assign poll_take = rd_lo & cfg.poll_arm;
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             a0,
    input  logic             rd,
    input  logic             wr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    input  logic [NLINE-1:0] irq_in,
    input  logic             inta,
    output logic             intr
);
    logic             wr_lo, wr_hi, rd_lo, rd_hi;
    cfg_t             cfg_q;
    logic [NLINE-1:0] imr_q, irr_q, isr_q;
    logic [NLINE-1:0] take_vec, eoi_clr, set_vec;
    logic             busy, armed, flush, eoi_any, eoi_spec, poll_take;
    logic [LVLW-1:0]  eoi_lvl;
    logic             live, take;
    pick_t            win, isr_top;

    assign wr_lo = cs & wr & ~a0;
    assign wr_hi = cs & wr & a0;
    assign rd_lo = cs & rd & ~a0;
    assign rd_hi = cs & rd & a0;

    pic8_bus u_bus (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo),
        .din(din), .cfg(cfg_q), .imr(imr_q), .busy(busy), .armed(armed),
        .flush(flush), .eoi_any(eoi_any), .eoi_spec(eoi_spec),
        .eoi_lvl(eoi_lvl), .poll_take(poll_take)
    );

    pic8_reqreg u_req (
        .clk(clk), .rst(rst), .lvl_trig(cfg_q.lvl_trig), .flush(flush),
        .line_in(irq_in), .take_vec(take_vec), .req(irr_q)
    );

    pic8_resolve u_res (
        .irr(irr_q), .imr(imr_q), .isr(isr_q), .spec_mask(cfg_q.spec_mask),
        .win(win)
    );

    assign live     = armed & ~busy;
    assign take     = (inta | poll_take) & win.hit & live;
    assign take_vec = take ? (NLINE'(1) << win.idx) : '0;
    assign set_vec  = cfg_q.auto_eoi ? '0 : take_vec;
    assign intr     = live & win.hit;

    always_comb begin
        isr_top = pick_first(isr_q);
        eoi_clr = '0;
        if (eoi_spec) begin
            eoi_clr = NLINE'(1) << eoi_lvl;
        end else if (eoi_any && isr_top.hit) begin
            eoi_clr = NLINE'(1) << isr_top.idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~eoi_clr) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (inta) begin
            dout <= {cfg_q.vbase, (take ? win.idx : {LVLW{1'b1}})};
        end else if (rd_hi) begin
            dout <= imr_q;
        end else if (poll_take) begin
            dout <= {take, {PADW{1'b0}}, (take ? win.idx : {LVLW{1'b0}})};
        end else if (rd_lo) begin
            dout <= cfg_q.show_isr ? isr_q : irr_q;
        end
    end
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       a0,
    input logic       wr,
    input logic       inta,
    input logic [7:0] din,
    input logic       intr,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic [7:0] isr,
    input logic       aeoi,
    input logic       busy
);
    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !intr);

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && a0 && !busy) |=> imr == $past(din));

    // R5
    intr_source_chk: assert property (@(posedge clk) disable iff (rst)
        intr |-> (irr & ~imr) != 8'h00);

    // R6
    ack_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (inta && intr && !aeoi && !(cs && wr))
        |=> $countones(isr) == $countones($past(isr)) + 1);

    // R7
    eoi_spec_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && !a0 && din[7:3] == 5'b01100 && !busy && !inta)
        |=> isr[$past(din[2:0])] == 1'b0);

    // R10
    aeoi_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (inta && aeoi && !(cs && wr)) |=> isr == $past(isr));
endmodule

bind pic8_ctrl pic8_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .a0(a0), .wr(wr), .inta(inta), .din(din),
    .intr(intr), .irr(irr_q), .imr(imr_q), .isr(isr_q),
    .aeoi(cfg_q.auto_eoi), .busy(busy)
);

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, a0 = 1'b0, rd = 1'b0, wr = 1'b0, inta = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic [7:0] dout;
    logic       intr;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pic8_ctrl dut (
        .clk(clk), .rst(rst), .cs(cs), .a0(a0), .rd(rd), .wr(wr), .din(din),
        .dout(dout), .irq_in(irq_in), .inta(inta), .intr(intr)
    );

    localparam logic [2:0] OWR = 3'd0, ORD = 3'd1, OACK = 3'd2, OIN = 3'd3, OINT = 3'd4;

    // {requirement, op, a0, data, expected}
    localparam logic [23:0] TBL [64] = '{
        {4'd1,  OWR,  1'b0, 8'h13, 8'h00}, // R1 edge, single, mode word
        {4'd1,  OIN,  1'b0, 8'h08, 8'h00}, // R1
        {4'd1,  OINT, 1'b0, 8'h00, 8'h00}, // R1 quiet during set-up
        {4'd1,  OWR,  1'b1, 8'h40, 8'h00}, // R1 base 0x40
        {4'd1,  OWR,  1'b1, 8'h01, 8'h00}, // R1 mode word
        {4'd5,  OINT, 1'b0, 8'h00, 8'h01}, // R5
        {4'd8,  OWR,  1'b0, 8'h0A, 8'h00}, // R8
        {4'd8,  ORD,  1'b0, 8'h00, 8'h08}, // R8 request register
        {4'd6,  OACK, 1'b0, 8'h00, 8'h43}, // R6
        {4'd3,  OINT, 1'b0, 8'h00, 8'h00}, // R3 held high, no new request
        {4'd8,  OWR,  1'b0, 8'h0B, 8'h00}, // R8
        {4'd8,  ORD,  1'b0, 8'h00, 8'h08}, // R8 in-service register
        {4'd5,  OIN,  1'b0, 8'h0C, 8'h00}, // R5 line 2 outranks 3
        {4'd5,  OINT, 1'b0, 8'h00, 8'h01}, // R5
        {4'd6,  OACK, 1'b0, 8'h00, 8'h42}, // R6
        {4'd5,  OIN,  1'b0, 8'h1C, 8'h00}, // R5 line 4 below service
        {4'd5,  OINT, 1'b0, 8'h00, 8'h00}, // R5 blocked
        {4'd7,  OWR,  1'b0, 8'h20, 8'h00}, // R7 non-specific
        {4'd7,  ORD,  1'b0, 8'h00, 8'h08}, // R7
        {4'd7,  OWR,  1'b0, 8'h63, 8'h00}, // R7 specific level 3
        {4'd7,  ORD,  1'b0, 8'h00, 8'h00}, // R7
        {4'd5,  OINT, 1'b0, 8'h00, 8'h01}, // R5 line 4 now free
        {4'd2,  OWR,  1'b1, 8'h10, 8'h00}, // R2 mask line 4
        {4'd2,  OINT, 1'b0, 8'h00, 8'h00}, // R2
        {4'd2,  ORD,  1'b1, 8'h00, 8'h10}, // R2 mask readback
        {4'd9,  OWR,  1'b0, 8'h0C, 8'h00}, // R9 poll
        {4'd9,  ORD,  1'b0, 8'h00, 8'h00}, // R9 nothing can win
        {4'd9,  OWR,  1'b1, 8'h00, 8'h00}, // R9 unmask
        {4'd9,  OWR,  1'b0, 8'h0C, 8'h00}, // R9 poll
        {4'd9,  ORD,  1'b0, 8'h00, 8'h84}, // R9 flag + level 4
        {4'd9,  ORD,  1'b0, 8'h00, 8'h10}, // R9 back to in-service read
        {4'd7,  OWR,  1'b0, 8'h20, 8'h00}, // R7
        {4'd7,  ORD,  1'b0, 8'h00, 8'h00}, // R7
        {4'd11, OIN,  1'b0, 8'h00, 8'h00}, // R11
        {4'd11, OIN,  1'b0, 8'h01, 8'h00}, // R11
        {4'd6,  OACK, 1'b0, 8'h00, 8'h40}, // R6
        {4'd11, OIN,  1'b0, 8'h41, 8'h00}, // R11 line 6 rises
        {4'd11, OWR,  1'b1, 8'h01, 8'h00}, // R11 mask in-service line 0
        {4'd11, OINT, 1'b0, 8'h00, 8'h00}, // R11 still blocked
        {4'd11, OWR,  1'b0, 8'h68, 8'h00}, // R11 special mask on
        {4'd11, OINT, 1'b0, 8'h00, 8'h01}, // R11
        {4'd11, OACK, 1'b0, 8'h00, 8'h46}, // R11
        {4'd11, OWR,  1'b0, 8'h48, 8'h00}, // R11 special mask off
        {4'd11, OWR,  1'b1, 8'h00, 8'h00}, // R11
        {4'd11, ORD,  1'b0, 8'h00, 8'h41}, // R11 two levels in service
        {4'd7,  OWR,  1'b0, 8'h20, 8'h00}, // R7
        {4'd7,  ORD,  1'b0, 8'h00, 8'h40}, // R7
        {4'd7,  OWR,  1'b0, 8'h20, 8'h00}, // R7
        {4'd7,  ORD,  1'b0, 8'h00, 8'h00}, // R7
        {4'd4,  OWR,  1'b0, 8'h1B, 8'h00}, // R4 level mode
        {4'd4,  OWR,  1'b1, 8'h80, 8'h00}, // R4 base 0x80
        {4'd4,  OWR,  1'b1, 8'h03, 8'h00}, // R4 automatic retire
        {4'd4,  OINT, 1'b0, 8'h00, 8'h01}, // R4
        {4'd4,  OACK, 1'b0, 8'h00, 8'h80}, // R4
        {4'd10, OWR,  1'b0, 8'h0B, 8'h00}, // R10
        {4'd10, ORD,  1'b0, 8'h00, 8'h00}, // R10 nothing in service
        {4'd10, OINT, 1'b0, 8'h00, 8'h01}, // R10 not blocked
        {4'd10, OACK, 1'b0, 8'h00, 8'h80}, // R10
        {4'd4,  OIN,  1'b0, 8'h40, 8'h00}, // R4
        {4'd4,  OACK, 1'b0, 8'h00, 8'h86}, // R4
        {4'd4,  OIN,  1'b0, 8'h20, 8'h00}, // R4
        {4'd4,  OINT, 1'b0, 8'h00, 8'h01}, // R4
        {4'd4,  OIN,  1'b0, 8'h00, 8'h00}, // R4 request vanishes
        {4'd4,  OACK, 1'b0, 8'h00, 8'h87}  // R4 spurious vector
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input logic [23:0] v);
        int req;
        req = int'(v[23:20]);
        case (v[19:17])
            OWR: begin
                cs = 1'b1; wr = 1'b1; a0 = v[16]; din = v[15:8];
                @(negedge clk);
                cs = 1'b0; wr = 1'b0;
            end
            ORD: begin
                cs = 1'b1; rd = 1'b1; a0 = v[16];
                @(negedge clk);
                cs = 1'b0; rd = 1'b0;
                check(req, dout, v[7:0]);
            end
            OACK: begin
                inta = 1'b1;
                @(negedge clk);
                inta = 1'b0;
                check(req, dout, v[7:0]);
            end
            OIN: begin
                irq_in = v[15:8];
                repeat (2) @(negedge clk);
            end
            default: check(req, {7'd0, intr}, v[7:0]);
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, dout, 8'h00);            // R1 reset state
        check(1, {7'd0, intr}, 8'h00);    // R1
        for (int i = 0; i < 64; i++) run(TBL[i]);

        // R1 cascade wiring: third word swallowed, mask untouched
        run({4'd1, OWR,  1'b0, 8'h10, 8'h00});
        run({4'd1, OWR,  1'b1, 8'h48, 8'h00});
        run({4'd1, OWR,  1'b1, 8'hFF, 8'h00});
        run({4'd1, ORD,  1'b1, 8'h00, 8'h00});
        run({4'd1, OIN,  1'b0, 8'h02, 8'h00});
        run({4'd1, OINT, 1'b0, 8'h00, 8'h01});
        run({4'd6, OACK, 1'b0, 8'h00, 8'h49});

        // R1 reset returns to an unprogrammed, silent controller
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, dout, 8'h00);
        run({4'd1, OIN,  1'b0, 8'h04, 8'h00});
        run({4'd1, OINT, 1'b0, 8'h00, 8'h00});
        run({4'd1, ORD,  1'b1, 8'h00, 8'h00});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule